// File: doc/BRIEF.md
# 64b/80b Lane Block Framer

This block turns a stream of already-scrambled 64-bit payload words into 80-bit parallel line blocks for one serial lane. Each incoming word arrives with a single sync transition bit. The block wraps the word in a two-bit sync header, which is never scrambled. It splits the word into eight octets and places a pair of pseudo-random fill bits in each of the seven gaps between neighbouring octets. The fill bits come from a free-running 17-bit PRBS generator. The generator advances only when a block is actually taken in, so the fill sequence continues unbroken from one block to the next.

The block also counts its place inside a 32-block multiblock. Every emitted block carries its index, and the last block of each multiblock is flagged. Scrambling, sync-word content and serialisation happen elsewhere. Both the input and the output are valid/ready handshakes, and a single output register stage sustains one block per cycle.

Top module: `fr80_framer`

## Requirements
- R1: Bit 79 of `out_block` is transmitted first. Bits [79:78] hold the header. Octet j (j = 0..7) sits at bits [77-10j -: 8], with D0 = `in_payload[63:56]` and D7 = `in_payload[7:0]`. Octets are copied unmodified and MSB first.
- R2: The header is `01` (bit 79 = 0, bit 78 = 1) when the accepted transition bit is 1, and `10` when it is 0.
- R3: Fill pair j (j = 0..6) sits at bits [69-10j -: 2], after octet j. The 14 fill bits, in transmit order, are successive outputs of a generator with state s[16:0]. Each step emits s[16] and then loads s <= {s[15:0], s[16]^s[13]} (x^17 + x^14 + 1). The state is 17'h1FFFF after reset.
- R4: The generator advances by exactly 14 steps for each accepted block and not at all otherwise. Fill bits therefore continue across blocks and across stalls without skipping or repeating.
- R5: `out_blk_idx` counts accepted blocks since reset, starting at 0 and wrapping from 31 back to 0.
- R6: `out_eomb` is 1 exactly when `out_blk_idx` is 31.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_block`, `out_blk_idx` and `out_eomb` hold their values and `in_ready` is 0.
- R8: `in_ready` is 1 whenever the output register is empty or is being drained in the same cycle. A continuous stream therefore moves one block per clock with no loss or duplication.
- R9: After a synchronous reset, `out_valid` is 0, `in_ready` is 1, the index restarts at 0 and the generator is reseeded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Payload word and transition bit are offered |
| in_ready | output | 1 | Framer can take the offered word this cycle |
| in_payload | input | 64 | Scrambled payload, D0 in the top octet |
| in_sync_bit | input | 1 | Sync transition bit for this block |
| out_valid | output | 1 | `out_block` holds a framed block |
| out_ready | input | 1 | Downstream takes the block this cycle |
| out_block | output | 80 | Framed block, bit 79 sent first |
| out_blk_idx | output | 5 | Position of the block in its multiblock |
| out_eomb | output | 1 | Block is the last of its multiblock |

## Verification
Two events can fall on the same clock edge: the output register releasing a held block and the input capturing the next word. The same edge also advances the fill generator and the multiblock counter. This is provoked by holding a block under backpressure with a second word waiting, then raising `out_ready`. It is also provoked by streaming 40 words back to back with `out_ready` held high, which crosses the block-31 wrap. Both cases are judged against a bench model. The model expects consecutive indices, a flag only on index 31, and fill bits that continue the generator sequence exactly where the previous block left it.

// File: rtl/fr80_pkg.sv
package fr80_pkg;
  localparam int OCT_W     = 8;
  localparam int N_OCT     = 8;
  localparam int HDR_W     = 2;
  localparam int FILL_W    = 2;
  localparam int PAY_W     = OCT_W * N_OCT;
  localparam int FILL_BITS = FILL_W * (N_OCT - 1);
  localparam int BLK_W     = HDR_W + PAY_W + FILL_BITS;
  localparam int MB_LEN    = 32;
  localparam int PRBS_LEN  = 17;
  localparam int PRBS_TAP  = 14;
  localparam logic [PRBS_LEN-1:0] PRBS_SEED = 17'h1FFFF;
endpackage

// File: rtl/fr80_prbs_fill.sv
module fr80_prbs_fill #(
  parameter int LEN   = 17,
  parameter int TAP   = 14,
  parameter int NBITS = 14,
  parameter logic [LEN-1:0] SEED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [NBITS-1:0] fill
);
  logic [LEN-1:0] state;
  logic [LEN-1:0] chain [0:NBITS];

  assign chain[0] = state;

  for (genvar i = 0; i < NBITS; i++) begin : g_step
    assign chain[i+1] = {chain[i][LEN-2:0], chain[i][LEN-1] ^ chain[i][TAP-1]};
    assign fill[NBITS-1-i] = chain[i][LEN-1];
  end

  always_ff @(posedge clk) begin
    if (rst)      state <= SEED;
    else if (adv) state <= chain[NBITS];
  end

  // The generator never falls into the all-zero lock-up state
  assert_prbs_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // No advance without an accepted block
  assert_prbs_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(state));
endmodule

// File: rtl/fr80_assemble.sv
module fr80_assemble #(
  parameter int OCT_W  = 8,
  parameter int N_OCT  = 8,
  parameter int HDR_W  = 2,
  parameter int FILL_W = 2,
  localparam int PAY_W     = OCT_W * N_OCT,
  localparam int FILL_BITS = FILL_W * (N_OCT - 1),
  localparam int BLK_W     = HDR_W + PAY_W + FILL_BITS,
  localparam int SLOT      = OCT_W + FILL_W
) (
  input  logic [PAY_W-1:0]     payload,
  input  logic                 sync_bit,
  input  logic [FILL_BITS-1:0] fill,
  output logic [BLK_W-1:0]     blk
);
  always_comb begin
    blk = '0;
    blk[BLK_W-1 -: HDR_W] = sync_bit ? 2'b01 : 2'b10;
    for (int j = 0; j < N_OCT; j++) begin
      blk[BLK_W-HDR_W-1-j*SLOT -: OCT_W] = payload[PAY_W-1-j*OCT_W -: OCT_W];
    end
    for (int j = 0; j < N_OCT - 1; j++) begin
      blk[BLK_W-HDR_W-1-j*SLOT-OCT_W -: FILL_W] = fill[FILL_BITS-1-j*FILL_W -: FILL_W];
    end
  end
endmodule

// File: rtl/fr80_mb_count.sv
module fr80_mb_count #(
  parameter int MB_LEN = 32,
  localparam int IDX_W = $clog2(MB_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  assign last = (idx == IDX_W'(MB_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= last ? '0 : idx + 1'b1;
  end

  assert_mb_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    adv && last |=> idx == '0);

  assert_mb_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(idx));
endmodule

// File: rtl/fr80_framer.sv
module fr80_framer
  import fr80_pkg::*;
#(
  parameter int OCT_W  = fr80_pkg::OCT_W,
  parameter int N_OCT  = fr80_pkg::N_OCT,
  parameter int FILL_W = fr80_pkg::FILL_W,
  parameter int MB_LEN = fr80_pkg::MB_LEN,
  localparam int PAY_W  = OCT_W * N_OCT,
  localparam int FBITS  = FILL_W * (N_OCT - 1),
  localparam int BW     = HDR_W + PAY_W + FBITS,
  localparam int IW     = $clog2(MB_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [PAY_W-1:0] in_payload,
  input  logic          in_sync_bit,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [BW-1:0] out_block,
  output logic [IW-1:0] out_blk_idx,
  output logic          out_eomb
);
  logic             accept;
  logic [FBITS-1:0] fill;
  logic [BW-1:0]    framed;
  logic [IW-1:0]    cur_idx;
  logic             cur_last;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  fr80_prbs_fill #(
    .LEN(PRBS_LEN), .TAP(PRBS_TAP), .NBITS(FBITS), .SEED(PRBS_SEED)
  ) u_prbs (
    .clk(clk), .rst(rst), .adv(accept), .fill(fill)
  );

  fr80_assemble #(
    .OCT_W(OCT_W), .N_OCT(N_OCT), .HDR_W(HDR_W), .FILL_W(FILL_W)
  ) u_asm (
    .payload(in_payload), .sync_bit(in_sync_bit), .fill(fill), .blk(framed)
  );

  fr80_mb_count #(.MB_LEN(MB_LEN)) u_cnt (
    .clk(clk), .rst(rst), .adv(accept), .idx(cur_idx), .last(cur_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_block   <= '0;
      out_blk_idx <= '0;
      out_eomb    <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_block   <= framed;
      out_blk_idx <= cur_idx;
      out_eomb    <= cur_last;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_block)
      && $stable(out_blk_idx) && $stable(out_eomb));

  assert_hdr_transition_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_block[BW-1] != out_block[BW-2]);

  assert_hdr_value_R2: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_block[BW-2] == $past(in_sync_bit));

  assert_eomb_idx_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_eomb == (out_blk_idx == IW'(MB_LEN - 1)));

  assert_accept_when_drain_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready |-> in_ready);
endmodule

// File: tb/fr80_framer_tb.sv
`timescale 1ns/1ps
module fr80_framer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_payload = '0;
  logic        in_sync_bit = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [79:0] out_block;
  logic [4:0]  out_blk_idx;
  logic        out_eomb;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  logic [16:0] mst;
  int nb;

  always #2.5 clk = ~clk;

  fr80_framer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(in_payload), .in_sync_bit(in_sync_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block),
    .out_blk_idx(out_blk_idx), .out_eomb(out_eomb)
  );

  // {expected header, transition bit, payload}
  localparam logic [66:0] VEC [6] = '{
    {2'b01, 1'b1, 64'h0123_4567_89AB_CDEF},
    {2'b10, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF},
    {2'b01, 1'b1, 64'h0000_0000_0000_0000},
    {2'b10, 1'b0, 64'hA5A5_5A5A_C3C3_3C3C},
    {2'b10, 1'b0, 64'h8000_0000_0000_0001},
    {2'b01, 1'b1, 64'hDEAD_BEEF_0BAD_F00D}
  };

  function automatic logic [79:0] model(input logic [63:0] p, input logic sb,
                                        inout logic [16:0] s);
    logic [79:0] b;
    b = '0;
    b[79:78] = sb ? 2'b01 : 2'b10;
    for (int j = 0; j < 8; j++) b[77-10*j -: 8] = p[63-8*j -: 8];
    for (int j = 0; j < 7; j++) begin
      for (int k = 0; k < 2; k++) begin
        b[69-10*j-k] = s[16];
        s = {s[15:0], s[16] ^ s[13]};
      end
    end
    return b;
  endfunction

  task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] p, input logic sb);
    @(negedge clk);
    in_valid = 1'b1; in_payload = p; in_sync_bit = sb;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] spay(input int k);
    return {32'h1357_0000 + 32'(k), 32'hC0DE_0000 ^ 32'(k * 7)};
  endfunction

  initial begin
    logic [79:0] exp;
    logic [79:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mst = 17'h1FFFF; nb = 0;
    // R9: reset state
    check("R9 out_valid after reset", 80'(out_valid), 80'd0);
    check("R9 in_ready after reset", 80'(in_ready), 80'd1);

    // Table walk: R1, R2, R3, R4, R5
    for (int v = 0; v < 6; v++) begin
      send(VEC[v][63:0], VEC[v][64]);
      exp = model(VEC[v][63:0], VEC[v][64], mst);
      check("R2 header", 80'(out_block[79:78]), 80'(VEC[v][66:65]));
      check("R1/R3/R4 block", out_block, exp);
      check("R5 index", 80'(out_blk_idx), 80'(nb));
      check("R6 eomb low", 80'(out_eomb), 80'd0);
      nb++;
    end
    @(negedge clk);
    check("R8 drained", 80'(out_valid), 80'd0);

    // Stall: R7, then same-edge drain and capture: R8, R4
    out_ready = 1'b0;
    send(64'h1122_3344_5566_7788, 1'b1);
    held = model(64'h1122_3344_5566_7788, 1'b1, mst);
    check("R7 held block", out_block, held);
    nb++;
    in_valid = 1'b1; in_payload = 64'h99AA_BBCC_DDEE_FF00; in_sync_bit = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R7 in_ready low", 80'(in_ready), 80'd0);
      check("R7 block stable", out_block, held);
      check("R7 index stable", 80'(out_blk_idx), 80'(nb - 1));
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(64'h99AA_BBCC_DDEE_FF00, 1'b0, mst);
    check("R8/R4 block after stall", out_block, exp);
    check("R8 valid after stall", 80'(out_valid), 80'd1);
    check("R5 index after stall", 80'(out_blk_idx), 80'(nb));
    nb++;

    // Back-to-back stream across the multiblock wrap: R5, R6, R8
    @(negedge clk);
    in_valid = 1'b1; in_payload = spay(0); in_sync_bit = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      exp = model(spay(k), k[0], mst);
      check("R8 stream block", out_block, exp);
      check("R5 stream index", 80'(out_blk_idx), 80'(nb % 32));
      check("R6 stream eomb", 80'(out_eomb), 80'((nb % 32) == 31));
      nb++;
      if (k < 39) begin
        in_payload = spay(k + 1); in_sync_bit = ~k[0];
      end else begin
        in_valid = 1'b0;
      end
    end

    // Mid-run reset: R9
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9 valid in reset", 80'(out_valid), 80'd0);
    rst = 1'b0;
    mst = 17'h1FFFF; nb = 0;
    send(64'h0F0F_F0F0_1234_5678, 1'b1);
    exp = model(64'h0F0F_F0F0_1234_5678, 1'b1, mst);
    check("R9/R3 reseeded block", out_block, exp);
    check("R9 index restart", 80'(out_blk_idx), 80'd0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule